// File: doc/BRIEF.md
# Dataflow Processing Element ALU

This block is the arithmetic and logic stage of a dataflow processing element. Each cycle it may accept one operation. The operation is chosen by a 5-bit opcode and works on a 16-bit left operand, a 16-bit right operand and a 4-bit immediate. Two-input operations use both operands. Single-input operations use the left operand only. The one exception is the constant load, which returns the right operand as the constant word supplied by instruction memory.

The result is registered. It appears one clock after the operation is accepted, together with an output valid. An opcode with no operation assigned gives a zero result and raises an illegal-operation flag for that one result cycle. When no operation is offered, the result register keeps its last value.

Top module: `dfpe_alu`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted and on the first edge after it, `out_valid`, `illegal_op` and `result` are all zero.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge. The result of an operation accepted at edge k is visible after edge k.
- R3: Opcode 0 returns lhs+rhs and opcode 1 returns lhs-rhs. Opcode 2 returns lhs+1 and opcode 3 returns lhs-1. All four wrap modulo 2^16, and opcodes 2 and 3 ignore rhs.
- R4: Opcode 4 shifts lhs left by imm+1 bits. Opcode 5 shifts lhs right by imm+1 bits. Both fill with zeros, so imm=15 gives zero.
- R5: Opcode 6 shifts lhs right by imm bits (0 to 15) and fills from bit 15, the sign bit.
- R6: Opcode 7 returns lhs AND rhs, opcode 8 returns OR and opcode 9 returns XOR. Opcode 10 returns the bitwise inverse of lhs.
- R7: Opcodes 11 to 15 compare lhs with rhs as signed two's-complement numbers. Opcode 11 tests equal, 12 less-than, 13 less-or-equal, 14 greater-than and 15 greater-or-equal. The result is 1 when true and 0 when false.
- R8: Opcode 16 returns lhs unchanged. Opcode 17 returns rhs as the loaded constant.
- R9: An accepted opcode from 18 to 31 gives result 0 and sets `illegal_op` high for exactly that one output cycle.
- R10: A cycle with `in_valid` low leaves `result` unchanged on the next cycle and keeps `illegal_op` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered this cycle |
| opcode | input | 5 | Operation select |
| lhs | input | 16 | Left operand, the only operand of single-input operations |
| rhs | input | 16 | Right operand, or the constant for opcode 17 |
| imm | input | 4 | Shift count field |
| out_valid | output | 1 | Result valid |
| result | output | 16 | Registered result |
| illegal_op | output | 1 | Unused opcode was accepted |

## Verification
The block holds only a result register and two flag bits. A wrong internal state therefore shows at the ports on the very next cycle. It appears as a wrong result word, a result that changes when no operation was offered, or a flag that is high or low when it should not be. The bench sweeps every opcode against every immediate value and several operand pairs chosen around the sign and carry boundaries. Each output is checked one cycle after the operation is offered, so a fault is reported at the first operation it corrupts.

// File: rtl/dfpe_alu.sv
module dfpe_alu #(
  parameter int W     = 16,
  parameter int OP_W  = 5,
  parameter int IMM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  opcode,
  input  logic [W-1:0]     lhs,
  input  logic [W-1:0]     rhs,
  input  logic [IMM_W-1:0] imm,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic             illegal_op
);
  localparam int SH_W = IMM_W + 1;

  localparam logic [OP_W-1:0] OP_ADD   = OP_W'(0);
  localparam logic [OP_W-1:0] OP_SUB   = OP_W'(1);
  localparam logic [OP_W-1:0] OP_INC   = OP_W'(2);
  localparam logic [OP_W-1:0] OP_DEC   = OP_W'(3);
  localparam logic [OP_W-1:0] OP_SHL   = OP_W'(4);
  localparam logic [OP_W-1:0] OP_SHR   = OP_W'(5);
  localparam logic [OP_W-1:0] OP_ASR   = OP_W'(6);
  localparam logic [OP_W-1:0] OP_AND   = OP_W'(7);
  localparam logic [OP_W-1:0] OP_OR    = OP_W'(8);
  localparam logic [OP_W-1:0] OP_XOR   = OP_W'(9);
  localparam logic [OP_W-1:0] OP_NOT   = OP_W'(10);
  localparam logic [OP_W-1:0] OP_EQ    = OP_W'(11);
  localparam logic [OP_W-1:0] OP_LT    = OP_W'(12);
  localparam logic [OP_W-1:0] OP_LTE   = OP_W'(13);
  localparam logic [OP_W-1:0] OP_GT    = OP_W'(14);
  localparam logic [OP_W-1:0] OP_GTE   = OP_W'(15);
  localparam logic [OP_W-1:0] OP_PASS  = OP_W'(16);
  localparam logic [OP_W-1:0] OP_CONST = OP_W'(17);

  logic [SH_W-1:0] sh_plus;
  logic            lt_s, eq_s;
  logic [W-1:0]    nxt;
  logic            bad;

  assign sh_plus = {1'b0, imm} + SH_W'(1);
  assign eq_s    = (lhs == rhs);
  assign lt_s    = ($signed(lhs) < $signed(rhs));

  always_comb begin
    nxt = '0;
    bad = 1'b0;
    case (opcode)
      OP_ADD:   nxt = lhs + rhs;
      OP_SUB:   nxt = lhs - rhs;
      OP_INC:   nxt = lhs + W'(1);
      OP_DEC:   nxt = lhs - W'(1);
      OP_SHL:   nxt = lhs << sh_plus;
      OP_SHR:   nxt = lhs >> sh_plus;
      OP_ASR:   nxt = W'($signed(lhs) >>> imm);
      OP_AND:   nxt = lhs & rhs;
      OP_OR:    nxt = lhs | rhs;
      OP_XOR:   nxt = lhs ^ rhs;
      OP_NOT:   nxt = ~lhs;
      OP_EQ:    nxt = W'(eq_s);
      OP_LT:    nxt = W'(lt_s);
      OP_LTE:   nxt = W'(lt_s | eq_s);
      OP_GT:    nxt = W'(!(lt_s | eq_s));
      OP_GTE:   nxt = W'(!lt_s);
      OP_PASS:  nxt = lhs;
      OP_CONST: nxt = rhs;
      default:  bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      illegal_op <= 1'b0;
      result     <= '0;
    end else begin
      out_valid  <= in_valid;
      illegal_op <= in_valid & bad;
      if (in_valid) result <= nxt;
    end
  end
endmodule

module dfpe_alu_chk #(
  parameter int W     = 16,
  parameter int OP_W  = 5,
  parameter int IMM_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [OP_W-1:0]  opcode,
  input logic [W-1:0]     lhs,
  input logic [IMM_W-1:0] imm,
  input logic             out_valid,
  input logic [W-1:0]     result,
  input logic             illegal_op
);
  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_inc_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_W'(2)) |=> result == $past(lhs) + W'(1));
  assert_cmp_bool_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode >= OP_W'(11) && opcode <= OP_W'(15)) |=> result[W-1:1] == '0);
  assert_illegal_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode >= OP_W'(18)) |=> illegal_op && result == '0);
  assert_illegal_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && !illegal_op);
endmodule

bind dfpe_alu dfpe_alu_chk #(.W(W), .OP_W(OP_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .lhs(lhs),
  .imm(imm), .out_valid(out_valid), .result(result), .illegal_op(illegal_op)
);

// File: tb/dfpe_alu_tb.sv
module dfpe_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  opcode = '0;
  logic [15:0] lhs = '0, rhs = '0;
  logic [3:0]  imm = '0;
  logic        out_valid, illegal_op;
  logic [15:0] result;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dfpe_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .lhs(lhs), .rhs(rhs), .imm(imm), .out_valid(out_valid),
    .result(result), .illegal_op(illegal_op)
  );

  function automatic int sv(input logic [15:0] x);
    return (x >= 16'h8000) ? int'(x) - 65536 : int'(x);
  endfunction

  function automatic logic [15:0] model(input int op, input logic [15:0] a,
                                        input logic [15:0] b, input int n);
    int d, s;
    case (op)
      0:  return 16'((int'(a) + int'(b)) % 65536);
      1:  return 16'((int'(a) - int'(b) + 65536) % 65536);
      2:  return 16'((int'(a) + 1) % 65536);
      3:  return 16'((int'(a) + 65535) % 65536);
      4:  return 16'((longint'(a) * (longint'(1) << (n + 1))) % 65536);
      5:  return 16'(int'(a) / (1 << (n + 1)));
      6: begin
        d = 1 << n; s = sv(a);
        s = (s >= 0) ? s / d : -((-s + d - 1) / d);
        return 16'(s);
      end
      7:  return a & b;
      8:  return a | b;
      9:  return a ^ b;
      10: return 16'(65535 - int'(a));
      11: return 16'(sv(a) == sv(b));
      12: return 16'(sv(a) <  sv(b));
      13: return 16'(sv(a) <= sv(b));
      14: return 16'(sv(a) >  sv(b));
      15: return 16'(sv(a) >= sv(b));
      16: return a;
      17: return b;
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tag(input int op);
    if (op <= 3) return "R3";
    if (op <= 5) return "R4";
    if (op == 6) return "R5";
    if (op <= 10) return "R6";
    if (op <= 15) return "R7";
    if (op <= 17) return "R8";
    return "R9";
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic run_op(input int op, input logic [15:0] a, input logic [15:0] b, input int n);
    logic [15:0] e;
    @(negedge clk);
    in_valid = 1'b1; opcode = 5'(op); lhs = a; rhs = b; imm = 4'(n);
    e = model(op, a, b, n);
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag(op), {16'h0, result}, {16'h0, e});
    chk("R9", {31'h0, illegal_op}, {31'h0, op >= 18});
    chk("R2", {31'h0, out_valid}, 32'h1);
  endtask

  initial begin
    logic [15:0] pa [8] = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000,
                            16'h1234, 16'hA5C3, 16'h0001, 16'h8001};
    logic [15:0] pb [8] = '{16'h0000, 16'h0001, 16'h8000, 16'h7FFF,
                            16'h1234, 16'h5A3C, 16'hFFFF, 16'h8001};
    logic [15:0] held;
    repeat (3) @(negedge clk);
    chk("R1", {15'h0, out_valid, illegal_op, result}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {15'h0, out_valid, illegal_op, result}, 32'h0);

    for (int op = 0; op < 32; op++)
      for (int n = 0; n < 16; n++)
        for (int p = 0; p < 8; p++)
          run_op(op, pa[p], pb[(p + n) % 8], n);

    // R3/R4 monadic ops ignore rhs; R5 sign fill at the boundaries
    run_op(2, 16'hFFFF, 16'h1234, 0);
    run_op(3, 16'h0000, 16'hFFFF, 0);
    run_op(5, 16'hFFFF, 16'h0000, 15);
    run_op(6, 16'h8000, 16'h0000, 15);

    // R10: hold and flag clear when no operation is offered
    run_op(8, 16'h00F0, 16'h0F00, 0);
    held = result;
    @(negedge clk);
    opcode = 5'd0; lhs = 16'h1111; rhs = 16'h2222;
    @(negedge clk);
    chk("R10", {16'h0, result}, {16'h0, held});
    chk("R10", {31'h0, illegal_op}, 32'h0);
    chk("R2", {31'h0, out_valid}, 32'h0);
    run_op(20, 16'h1111, 16'h2222, 3);
    @(negedge clk);
    chk("R9", {31'h0, illegal_op}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule